// File: doc/BRIEF.md
# Nibble-Mode Video Output Serializer

This block turns a stream of video bytes into a stream of 4-bit nibbles for a narrow output port. Its clock runs at the nibble rate. Each cycle produces at most one nibble, which is placed on the upper four lines of an 8-bit output bus. The lower lines of that bus are held at zero. Every byte leaves as its high nibble and then its low nibble, and an output strobe marks each cycle that carries a valid nibble.

Two modes are available. Mono mode covers black-and-white or single-channel raw data: one Y byte per word, sent as two nibbles, so the nibble rate is twice the byte rate. Colour mode covers YUV 4:2:2 data: each 16-bit word carries a chroma byte and a luma byte, and the chroma byte goes out first, so each word becomes four nibbles. In colour mode the upstream source runs in 8-bit style and puts U and V on alternate words. The serial result is then U0H U0L Y0H Y0L V0H V0L Y1H Y1L. The block does not look at the meaning of the bytes, so YCrCb, raw RGB, and either embedded-code or separate-sync line timing all pass through unchanged.

The mode is sampled per word, at the cycle the word is accepted. A delayed line-valid output rises together with the first nibble of a line and falls once the last nibble of that line has gone out.

Top module: `nibble_serializer`

## Requirements
- R1: The nibble is driven on out_bus[7:4]. out_bus[3:0] is always 0, and out_bus is all-zero in any cycle without a strobe.
- R2: In mono mode (in_colour=0), an accepted word gives exactly two strobed cycles. The first comes in the cycle after acceptance and carries in_y[7:4]. The next cycle carries in_y[3:0].
- R3: In colour mode (in_colour=1), an accepted word gives four strobed cycles in a row, carrying in_uv[7:4], in_uv[3:0], in_y[7:4] and in_y[3:0] in that order. When the source alternates U and V on successive words, the stream reads U0H U0L Y0H Y0L V0H V0L Y1H Y1L.
- R4: A word is accepted at a clock edge where in_valid=1, in_href=1 and no nibble of an earlier word is still pending. in_colour is sampled at that edge only, so the mode can change from word to word.
- R5: A word offered while earlier nibbles are still pending is dropped. A word offered with in_href=0 is ignored. Neither one produces a strobe.
- R6: out_href rises in the same cycle as the first nibble of a line. It stays high through the last nibble of that line and falls once in_href is low and no nibble is pending. out_strobe is never high while out_href is low.
- R7: Synchronous active-high reset clears out_bus, out_strobe and out_href to 0 and discards any pending nibbles.
- R8: Words presented at the minimum spacing (every 2 cycles in mono mode, every 4 in colour mode) produce an unbroken strobe with no idle cycle between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_href | input | 1 | Line-valid window from upstream |
| in_valid | input | 1 | Word present on in_y / in_uv this cycle |
| in_colour | input | 1 | 1 = colour 4:2:2 word (chroma then luma), 0 = mono Y byte |
| in_y | input | 8 | Luma or single-channel byte |
| in_uv | input | 8 | Chroma byte (U or V, chosen by the source) |
| out_bus | output | 8 | Nibble on bits [7:4], bits [3:0] held at 0 |
| out_strobe | output | 1 | High in each cycle carrying a valid nibble |
| out_href | output | 1 | Line-valid, delayed to line up with the first nibble |

## Verification
Random lines of mono words, colour words and per-word mixed modes are sent, with random gaps between words. The nibbles are rebuilt into bytes and compared, in order, with the expected byte stream: Y alone for mono words, chroma then luma for colour words. A wrong nibble order or a wrong chroma/luma order shows up as a byte mismatch. Back-to-back words at minimum spacing separate a correct pending-count handoff from an off-by-one that would add or lose a cycle. Directed cases cover the exact cycle of the first nibble, words offered while busy, words offered outside the line window, and a reset in the middle of a word. Each of these is told apart by whether a strobe appears where the requirements allow none.

// File: rtl/nibser_pkg.sv
package nibser_pkg;
  typedef enum logic {
    MODE_MONO   = 1'b0,
    MODE_COLOUR = 1'b1
  } nib_mode_e;
endpackage

// File: rtl/nibser_loader.sv
// Builds the word to be shifted out and its nibble count from the input bytes.
module nibser_loader #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int SW    = 2 * BYTE_W,
  localparam int MAXN  = SW / NIB_W,
  localparam int CW    = $clog2(MAXN + 1)
) (
  input  nibser_pkg::nib_mode_e mode,
  input  logic [BYTE_W-1:0]     y_byte,
  input  logic [BYTE_W-1:0]     c_byte,
  output logic [SW-1:0]         word,
  output logic [CW-1:0]         count
);
  localparam int MONO_N = BYTE_W / NIB_W;

  always_comb begin
    if (mode == nibser_pkg::MODE_COLOUR) begin
      word  = {c_byte, y_byte};
      count = CW'(MAXN);
    end else begin
      word  = {y_byte, {BYTE_W{1'b0}}};
      count = CW'(MONO_N);
    end
  end
endmodule

// File: rtl/nibser_shifter.sv
// Shift register emitting one nibble per cycle, most significant first.
module nibser_shifter #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int SW    = 2 * BYTE_W,
  localparam int MAXN  = SW / NIB_W,
  localparam int CW    = $clog2(MAXN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SW-1:0]    word,
  input  logic [CW-1:0]    count,
  output logic [NIB_W-1:0] nib,
  output logic             stb,
  output logic             busy
);
  logic [SW-1:0] sh;
  logic [CW-1:0] rem;

  assign busy = (rem != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      rem <= '0;
      nib <= '0;
      stb <= 1'b0;
    end else if (load) begin
      nib <= word[SW-1 -: NIB_W];
      sh  <= {word[SW-NIB_W-1:0], {NIB_W{1'b0}}};
      rem <= count - CW'(1);
      stb <= 1'b1;
    end else if (busy) begin
      nib <= sh[SW-1 -: NIB_W];
      sh  <= {sh[SW-NIB_W-1:0], {NIB_W{1'b0}}};
      rem <= rem - CW'(1);
      stb <= 1'b1;
    end else begin
      nib <= '0;
      stb <= 1'b0;
    end
  end
endmodule

// File: rtl/nibser_href.sv
// Delayed line-valid: rises with the first nibble, drops after the last.
module nibser_href (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic busy,
  input  logic in_href,
  output logic href_o
);
  always_ff @(posedge clk) begin
    if (rst)        href_o <= 1'b0;
    else if (load)  href_o <= 1'b1;
    else if (!busy) href_o <= href_o & in_href;
  end
endmodule

// File: rtl/nibble_serializer.sv
module nibble_serializer #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int SW    = 2 * BYTE_W,
  localparam int MAXN  = SW / NIB_W,
  localparam int CW    = $clog2(MAXN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_href,
  input  logic              in_valid,
  input  logic              in_colour,
  input  logic [BYTE_W-1:0] in_y,
  input  logic [BYTE_W-1:0] in_uv,
  output logic [BYTE_W-1:0] out_bus,
  output logic              out_strobe,
  output logic              out_href
);
  logic [SW-1:0]    word;
  logic [CW-1:0]    count;
  logic [NIB_W-1:0] nib;
  logic             busy;
  logic             load;
  nibser_pkg::nib_mode_e mode;

  assign mode = in_colour ? nibser_pkg::MODE_COLOUR : nibser_pkg::MODE_MONO;
  assign load = in_valid & in_href & ~busy;

  nibser_loader #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_loader (
    .mode(mode), .y_byte(in_y), .c_byte(in_uv), .word(word), .count(count)
  );

  nibser_shifter #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .word(word), .count(count),
    .nib(nib), .stb(out_strobe), .busy(busy)
  );

  nibser_href u_href (
    .clk(clk), .rst(rst), .load(load), .busy(busy), .in_href(in_href),
    .href_o(out_href)
  );

  generate
    if (BYTE_W > NIB_W) begin : g_pad
      assign out_bus = {nib, {(BYTE_W-NIB_W){1'b0}}};
    end else begin : g_nopad
      assign out_bus = nib;
    end
  endgenerate
endmodule

// File: rtl/nibser_checker.sv
module nibser_checker #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_href,
  input logic              in_valid,
  input logic              in_colour,
  input logic [BYTE_W-1:0] in_y,
  input logic [BYTE_W-1:0] in_uv,
  input logic [BYTE_W-1:0] out_bus,
  input logic              out_strobe,
  input logic              out_href,
  input logic              busy
);
  logic acc;
  assign acc = in_valid & in_href & ~busy;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_strobe && !out_href && out_bus == '0)); // R7

  AST_MONO_FIRST: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_colour) |=> (out_strobe &&
      out_bus[BYTE_W-1 -: NIB_W] == $past(in_y[BYTE_W-1 -: NIB_W]))); // R2

  AST_COLOUR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (acc && in_colour) |=> (out_strobe &&
      out_bus[BYTE_W-1 -: NIB_W] == $past(in_uv[BYTE_W-1 -: NIB_W]))); // R3

  AST_PENDING_STROBES: assert property (@(posedge clk) disable iff (rst)
    busy |=> out_strobe); // R8

  AST_STROBE_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    out_strobe |-> out_href); // R6

  AST_HREF_WITH_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(out_href) |-> out_strobe); // R6

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_strobe |-> (out_bus == '0)); // R1
endmodule

bind nibble_serializer nibser_checker #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/nibble_serializer_tb.sv
module nibble_serializer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_href = 1'b0, in_valid = 1'b0, in_colour = 1'b0;
  logic [7:0] in_y = '0, in_uv = '0;
  logic [7:0] out_bus;
  logic       out_strobe, out_href;

  int n_chk = 0, n_fail = 0;
  int strobes = 0, href_rises = 0, lines_sent = 0;
  bit mon_en = 1'b0, done = 1'b0;
  bit half = 1'b0;
  logic [3:0] hi_nib;
  logic prev_href = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  nibble_serializer u_dut (
    .clk(clk), .rst(rst), .in_href(in_href), .in_valid(in_valid),
    .in_colour(in_colour), .in_y(in_y), .in_uv(in_uv),
    .out_bus(out_bus), .out_strobe(out_strobe), .out_href(out_href)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: rebuild bytes from nibbles and compare to the expected stream.
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (out_href && !prev_href) begin
        href_rises++;
        check(out_strobe && !half, "R6 href rise not on first nibble", {out_strobe, half}, 2'b10);
      end
      if (out_strobe) begin
        strobes++;
        check(out_bus[3:0] == 4'h0, "R1 low bits nonzero", out_bus, {out_bus[7:4], 4'h0});
        check(out_href, "R6 strobe outside href", out_href, 1);
        if (!half) begin
          hi_nib = out_bus[7:4];
          half = 1'b1;
        end else begin
          half = 1'b0;
          if (exp_q.size() == 0)
            check(0, "R2/R3 unexpected byte", {hi_nib, out_bus[7:4]}, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check({hi_nib, out_bus[7:4]} == e, "R2/R3 byte mismatch", {hi_nib, out_bus[7:4]}, e);
          end
        end
      end else begin
        check(out_bus == 8'h00, "R1 idle bus nonzero", out_bus, 0);
      end
      prev_href = out_href;
    end
  end

  task automatic send_word(input bit col, input logic [7:0] y, input logic [7:0] uv, input int gap);
    in_valid = 1'b1; in_colour = col; in_y = y; in_uv = uv;
    if (col) exp_q.push_back(uv);
    exp_q.push_back(y);
    @(negedge clk);
    in_valid = 1'b0;
    repeat ((col ? 3 : 1) + gap) @(negedge clk);
  endtask

  task automatic send_line(input int mode_sel, input int nwords, input int maxgap);
    in_href = 1'b1;
    @(negedge clk);
    for (int w = 0; w < nwords; w++) begin
      bit col;
      col = (mode_sel == 2) ? bit'($urandom_range(0, 1)) : bit'(mode_sel);
      send_word(col, 8'($urandom), 8'($urandom), (maxgap == 0) ? 0 : int'($urandom_range(0, maxgap)));
    end
    in_href = 1'b0;
    lines_sent++;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R7: reset state
    check(out_strobe == 0 && out_href == 0 && out_bus == 0, "R7 reset state",
          {out_strobe, out_href, out_bus}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 directed timing: mono word A5, nibbles in the two cycles after acceptance
    in_href = 1'b1; in_valid = 1'b1; in_colour = 1'b0; in_y = 8'hA5; in_uv = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_strobe && out_bus == 8'hA0, "R2 first nibble", {out_strobe, out_bus}, {1'b1, 8'hA0});
    check(out_href, "R6 href with first nibble", out_href, 1);
    @(negedge clk);
    check(out_strobe && out_bus == 8'h50, "R2 second nibble", {out_strobe, out_bus}, {1'b1, 8'h50});
    @(negedge clk);
    check(!out_strobe, "R2 only two nibbles", out_strobe, 0);
    in_href = 1'b0;
    @(negedge clk);
    check(!out_href, "R6 href falls after line", out_href, 1'b0);

    // R3 directed: colour word uv=3C y=E1 -> 3,C,E,1
    in_href = 1'b1; in_valid = 1'b1; in_colour = 1'b1; in_y = 8'hE1; in_uv = 8'h3C;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_bus == 8'h30 && out_strobe, "R3 nibble 0", out_bus, 8'h30);
    @(negedge clk);
    check(out_bus == 8'hC0 && out_strobe, "R3 nibble 1", out_bus, 8'hC0);
    @(negedge clk);
    check(out_bus == 8'hE0 && out_strobe, "R3 nibble 2", out_bus, 8'hE0);
    @(negedge clk);
    check(out_bus == 8'h10 && out_strobe, "R3 nibble 3", out_bus, 8'h10);
    @(negedge clk);
    check(!out_strobe, "R3 only four nibbles", out_strobe, 0);
    in_href = 1'b0;
    repeat (3) @(negedge clk);

    // Monitor-based phase from here on
    mon_en = 1'b1;

    // R5: second word offered while busy is dropped
    in_href = 1'b1; @(negedge clk);
    in_valid = 1'b1; in_colour = 1'b0; in_y = 8'h11; exp_q.push_back(8'h11);
    @(negedge clk);
    in_y = 8'h99;  // offered while the first word is pending
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    in_href = 1'b0; lines_sent++;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 busy word dropped", exp_q.size(), 0);

    // R5: word with href low is ignored
    begin
      int s0;
      s0 = strobes;
      in_valid = 1'b1; in_y = 8'h77;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(strobes == s0, "R5 href-low word ignored", strobes, s0);
      check(!out_href, "R5 href stays low", out_href, 0);
    end

    // R8: back-to-back words at minimum spacing give a gapless strobe
    begin
      int s0;
      s0 = strobes;
      send_line(0, 6, 0);
      check(strobes == s0 + 12, "R8 mono back-to-back strobes", strobes, s0 + 12);
      s0 = strobes;
      send_line(1, 6, 0);
      check(strobes == s0 + 24, "R8 colour back-to-back strobes", strobes, s0 + 24);
    end

    // R3 chroma alternation: U0 Y0 V0 Y1 order
    in_href = 1'b1; @(negedge clk);
    send_word(1'b1, 8'h10, 8'hA0, 0);
    send_word(1'b1, 8'h11, 8'hB0, 0);
    in_href = 1'b0; lines_sent++;
    repeat (4) @(negedge clk);

    // Random lines, mono / colour / mixed (R4), with gaps
    for (int l = 0; l < 40; l++)
      send_line(l % 3, int'($urandom_range(1, 12)), 3);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4 all accepted words delivered", exp_q.size(), 0);
    check(href_rises == lines_sent, "R6 one href pulse per line", href_rises, lines_sent);

    // R7: reset in the middle of a colour word discards pending nibbles
    mon_en = 1'b0;
    in_href = 1'b1; in_valid = 1'b1; in_colour = 1'b1; in_y = 8'h5A; in_uv = 8'hC3;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(out_strobe == 0 && out_href == 0 && out_bus == 0, "R7 mid-word reset",
          {out_strobe, out_href, out_bus}, 0);
    rst = 1'b0; in_href = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!out_strobe, "R7 pending nibbles discarded", out_strobe, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule